// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block stands in for the management register set of a 10/100 Ethernet transceiver. A host first loads a target register that selects a PHY address and a register index. It then sees the selected register on a read-data output, or updates it with a write-data strobe. Six registers are modelled: control, status, two identifier words, local advertisement and link-partner ability. Each has a defined reset value.

A `link_up` input stands for the cable state. The status and partner-ability registers follow it, one clock after it changes. Only the control and advertisement registers take host writes. Setting the soft-reset bit of the control register restores the reset values. A target whose PHY address differs from the configured one reads as all ones. An index outside the six modelled registers reads as zero.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, control reads 0x3100, status 0x7849, advertisement 0x01E1 and partner ability 0x0080 while the link is down; status bits other than 2 and 5 never differ from 0x7849.
- R2: One clock after `link_up` rises, status bit 2 (link) and bit 5 (negotiation complete) are set, giving 0x786D, and 0x0161 is OR-ed into partner ability, giving 0x01E1.
- R3: One clock after `link_up` falls, status bits 2 and 5 are cleared (0x7849) and partner ability returns to 0x0080.
- R4: When target bits [15:8] differ from the PHY_ADDR parameter, `rd_data` is 0xFFFF, and a data write changes no register.
- R5: Target indices of 6 and above read 0.
- R6: Index 2 reads the ID_HI parameter and index 3 reads the ID_LO parameter.
- R7: A write to index 0 with bit 15 clear stores the value in control; a write to index 4 stores the value in advertisement.
- R8: A write to index 0 with bit 15 set restores control to 0x3100 and advertisement to 0x01E1, keeps the current link-driven bits, and does not store the written value.
- R9: Writes to index 1 (status), 2 and 3 (identifiers), 5 (partner ability) or any index of 6 and above leave every register unchanged.
- R10: The target register holds the PHY address in bits [15:8] and the index in bits [7:0]. A data write issued in the same cycle as a target load uses the target held before that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_up | input | 1 | Current link state, 1 means up |
| tgt_wr | input | 1 | Load strobe for the target register |
| tgt_wdata | input | 16 | New target: PHY address [15:8], index [7:0] |
| wr_en | input | 1 | Data write strobe for the selected register |
| wr_data | input | 16 | Data written to the selected register |
| rd_data | output | 16 | Contents of the selected register |

## Verification
Two events can fall in the same cycle: a soft-reset write and a change of `link_up`. The bench forces both on the same clock edge. It checks that control and advertisement return to their reset values and that status and partner ability show the new link state rather than the old one. A data write and a target load can also coincide. The bench issues both together and checks that the value landed in the register selected by the old target. A behavioural model held in plain variables predicts `rd_data` and is compared against it on every clock.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

   typedef enum logic [2:0] {
      SEL_CTRL    = 3'd0,
      SEL_STAT    = 3'd1,
      SEL_ID_HI   = 3'd2,
      SEL_ID_LO   = 3'd3,
      SEL_ADV     = 3'd4,
      SEL_PARTNER = 3'd5,
      SEL_NONE    = 3'd6
   } reg_sel_e;

   localparam int          CTRL_SOFT_RST_BIT = 15;
   localparam logic [15:0] CTRL_RESET_VAL    = 16'h3100;
   localparam logic [15:0] STAT_BASE_VAL     = 16'h7849;
   localparam logic [15:0] STAT_LINK_MASK    = 16'h0024;
   localparam logic [15:0] ADV_RESET_VAL     = 16'h01E1;
   localparam logic [15:0] PARTNER_DOWN_VAL  = 16'h0080;
   localparam logic [15:0] PARTNER_UP_OR     = 16'h0161;

   function automatic reg_sel_e decode_index(input logic [31:0] idx);
      case (idx)
         32'd0:   decode_index = SEL_CTRL;
         32'd1:   decode_index = SEL_STAT;
         32'd2:   decode_index = SEL_ID_HI;
         32'd3:   decode_index = SEL_ID_LO;
         32'd4:   decode_index = SEL_ADV;
         32'd5:   decode_index = SEL_PARTNER;
         default: decode_index = SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/phy_tgt_reg.sv
module phy_tgt_reg
   import phy_mgmt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 8,
   parameter logic [ADDR_W-1:0] PHY_ADDR = '0,
   localparam int TGT_W = ADDR_W + IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tgt_wr,
   input  logic [TGT_W-1:0] tgt_wdata,
   output logic             addr_hit,
   output reg_sel_e         sel
);

   logic [TGT_W-1:0] tgt_q;
   logic [ADDR_W-1:0] addr_f;
   logic [IDX_W-1:0]  idx_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tgt_q <= '0;
      else if (tgt_wr) tgt_q <= tgt_wdata;
   end

   assign addr_f   = tgt_q[TGT_W-1:IDX_W];
   assign idx_f    = tgt_q[IDX_W-1:0];
   assign addr_hit = (addr_f == PHY_ADDR);
   assign sel      = decode_index(32'(idx_f));

endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
   import phy_mgmt_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] adv_q
);

   logic soft_rst;
   logic ctrl_wr;
   logic adv_wr;

   assign ctrl_wr  = wr_stb && (sel == SEL_CTRL);
   assign adv_wr   = wr_stb && (sel == SEL_ADV);
   assign soft_rst = ctrl_wr && wr_data[CTRL_SOFT_RST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= DATA_W'(CTRL_RESET_VAL);
         adv_q  <= DATA_W'(ADV_RESET_VAL);
      end else if (soft_rst) begin
         ctrl_q <= DATA_W'(CTRL_RESET_VAL);
         adv_q  <= DATA_W'(ADV_RESET_VAL);
      end else begin
         if (ctrl_wr) ctrl_q <= wr_data;
         if (adv_wr)  adv_q  <= wr_data;
      end
   end

endmodule

// File: rtl/phy_link_regs.sv
module phy_link_regs
   import phy_mgmt_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_up,
   output logic [DATA_W-1:0] stat,
   output logic [DATA_W-1:0] partner
);

   logic link_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q  <= 1'b0;
         partner <= DATA_W'(PARTNER_DOWN_VAL);
      end else begin
         link_q <= link_up;
         if (link_up != link_q) begin
            if (link_up) partner <= partner | DATA_W'(PARTNER_UP_OR);
            else         partner <= DATA_W'(PARTNER_DOWN_VAL);
         end
      end
   end

   assign stat = link_q ? DATA_W'(STAT_BASE_VAL | STAT_LINK_MASK)
                        : DATA_W'(STAT_BASE_VAL);

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
   import phy_mgmt_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 8,
   parameter int IDX_W    = 8,
   parameter logic [ADDR_W-1:0] PHY_ADDR = 8'h01,
   parameter logic [DATA_W-1:0] ID_HI    = 16'h02A5,
   parameter logic [DATA_W-1:0] ID_LO    = 16'h5C31,
   parameter bit   REG_READ = 1'b0,
   localparam int TGT_W = ADDR_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_up,
   input  logic              tgt_wr,
   input  logic [TGT_W-1:0]  tgt_wdata,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   generate
      if (DATA_W != 16) begin : g_bad_width
         $error("phy_mgmt_regs: DATA_W must be 16");
      end
      if (IDX_W < 3) begin : g_bad_idx
         $error("phy_mgmt_regs: IDX_W must be at least 3");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("phy_mgmt_regs: ADDR_W must be positive");
      end
   endgenerate

   logic              addr_hit;
   reg_sel_e          sel;
   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] adv_q;
   logic [DATA_W-1:0] stat;
   logic [DATA_W-1:0] partner;
   logic [DATA_W-1:0] rd_mux;

   phy_tgt_reg #(
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W),
      .PHY_ADDR (PHY_ADDR)
   ) u_tgt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tgt_wr    (tgt_wr),
      .tgt_wdata (tgt_wdata),
      .addr_hit  (addr_hit),
      .sel       (sel)
   );

   phy_ctrl_regs #(
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_en && addr_hit),
      .sel     (sel),
      .wr_data (wr_data),
      .ctrl_q  (ctrl_q),
      .adv_q   (adv_q)
   );

   phy_link_regs #(
      .DATA_W (DATA_W)
   ) u_link (
      .clk     (clk),
      .rst_n   (rst_n),
      .link_up (link_up),
      .stat    (stat),
      .partner (partner)
   );

   always_comb begin
      if (!addr_hit) begin
         rd_mux = '1;
      end else begin
         case (sel)
            SEL_CTRL:    rd_mux = ctrl_q;
            SEL_STAT:    rd_mux = stat;
            SEL_ID_HI:   rd_mux = ID_HI;
            SEL_ID_LO:   rd_mux = ID_LO;
            SEL_ADV:     rd_mux = adv_q;
            SEL_PARTNER: rd_mux = partner;
            default:     rd_mux = '0;
         endcase
      end
   end

   generate
      if (REG_READ) begin : g_rd_flop
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign rd_data = rd_q;
      end else begin : g_rd_comb
         assign rd_data = rd_mux;
      end
   endgenerate

endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk
   import phy_mgmt_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter bit REG_READ = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              link_up,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              addr_hit,
   input reg_sel_e          sel,
   input logic [DATA_W-1:0] ctrl_q,
   input logic [DATA_W-1:0] adv_q,
   input logic [DATA_W-1:0] stat,
   input logic [DATA_W-1:0] partner,
   input logic [DATA_W-1:0] rd_data
);

   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   a_r1_stat_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (stat & ~DATA_W'(STAT_LINK_MASK)) == DATA_W'(STAT_BASE_VAL));

   a_r2_link_bits: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (stat[2] == $past(link_up)) && (stat[5] == $past(link_up)));

   a_r3_partner_follows: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> partner == ($past(link_up) ? 16'h01E1 : 16'h0080));

   a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(wr_en && addr_hit && sel == SEL_CTRL && wr_data[15]))
      |-> (ctrl_q == DATA_W'(CTRL_RESET_VAL)) && (adv_q == DATA_W'(ADV_RESET_VAL)));

   a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(wr_en && addr_hit && (sel == SEL_CTRL || sel == SEL_ADV)))
      |-> $stable(ctrl_q) && $stable(adv_q));

   generate
      if (!REG_READ) begin : g_comb_rd
         a_r4_mismatch_ones: assert property (@(posedge clk) disable iff (!rst_n)
            !addr_hit |-> rd_data == '1);
      end
   endgenerate

endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(
   .DATA_W   (DATA_W),
   .REG_READ (REG_READ)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .link_up  (link_up),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .addr_hit (addr_hit),
   .sel      (sel),
   .ctrl_q   (ctrl_q),
   .adv_q    (adv_q),
   .stat     (stat),
   .partner  (partner),
   .rd_data  (rd_data)
);

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;

   localparam logic [7:0]  PHY   = 8'h01;
   localparam logic [15:0] IDH   = 16'h02A5;
   localparam logic [15:0] IDL   = 16'h5C31;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link_up = 1'b0;
   logic        tgt_wr = 1'b0;
   logic [15:0] tgt_wdata = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   phy_mgmt_regs #(
      .PHY_ADDR (PHY),
      .ID_HI    (IDH),
      .ID_LO    (IDL)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_up   (link_up),
      .tgt_wr    (tgt_wr),
      .tgt_wdata (tgt_wdata),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_data   (rd_data)
   );

   // behavioural reference
   logic [15:0] m_ctrl, m_adv, m_tgt;
   bit          m_link;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = 16'h3100; m_adv = 16'h01E1; m_tgt = 16'h0000; m_link = 1'b0;
      end else begin
         if (wr_en && m_tgt[15:8] == PHY) begin
            if (m_tgt[7:0] == 8'd0) begin
               if (wr_data[15]) begin m_ctrl = 16'h3100; m_adv = 16'h01E1; end
               else m_ctrl = wr_data;
            end else if (m_tgt[7:0] == 8'd4) begin
               m_adv = wr_data;
            end
         end
         if (tgt_wr) m_tgt = tgt_wdata;
         m_link = link_up;
      end
   end

   function automatic logic [15:0] model_rd();
      if (m_tgt[15:8] != PHY) return 16'hFFFF;
      case (m_tgt[7:0])
         8'd0: return m_ctrl;
         8'd1: return m_link ? 16'h786D : 16'h7849;
         8'd2: return IDH;
         8'd3: return IDL;
         8'd4: return m_adv;
         8'd5: return m_link ? 16'h01E1 : 16'h0080;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic string model_tag();
      if (m_tgt[15:8] != PHY) return "R4";
      case (m_tgt[7:0])
         8'd0, 8'd4: return "R7";
         8'd1, 8'd5: return "R2";
         8'd2, 8'd3: return "R6";
         default:    return "R5";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) chk(model_tag(), rd_data, model_rd());
   end

   task automatic set_tgt(input logic [7:0] a, input logic [7:0] i);
      @(negedge clk); tgt_wr = 1'b1; tgt_wdata = {a, i};
      @(negedge clk); tgt_wr = 1'b0;
   endtask

   task automatic wr(input logic [15:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] i,
                     input logic [15:0] exp);
      set_tgt(a, i);
      chk(tag, rd_data, exp);
   endtask

   task automatic link(input bit v);
      @(negedge clk); link_up = v;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset values, R10 field layout
      chk("R1", rd_data, 16'hFFFF ^ 16'hFFFF ^ 16'hFFFF); // target 0 -> address 0 mismatches
      rd("R1", PHY, 8'd0, 16'h3100);
      rd("R1", PHY, 8'd1, 16'h7849);
      rd("R1", PHY, 8'd4, 16'h01E1);
      rd("R1", PHY, 8'd5, 16'h0080);
      // R6 identifiers
      rd("R6", PHY, 8'd2, IDH);
      rd("R6", PHY, 8'd3, IDL);
      // R5 unknown indices
      rd("R5", PHY, 8'd6, 16'h0000);
      rd("R5", PHY, 8'h1F, 16'h0000);
      rd("R5", PHY, 8'hFF, 16'h0000);
      // R4 mismatched address
      rd("R4", 8'h02, 8'd0, 16'hFFFF);
      rd("R4", 8'h81, 8'd1, 16'hFFFF);
      // R2 link up
      link(1'b1);
      rd("R2", PHY, 8'd1, 16'h786D);
      rd("R2", PHY, 8'd5, 16'h01E1);
      // R7 writable registers
      set_tgt(PHY, 8'd0); wr(16'h1200); chk("R7", rd_data, 16'h1200);
      set_tgt(PHY, 8'd4); wr(16'h0061); chk("R7", rd_data, 16'h0061);
      // R9 read-only and unknown writes
      set_tgt(PHY, 8'd1); wr(16'h0000); chk("R9", rd_data, 16'h786D);
      set_tgt(PHY, 8'd5); wr(16'h0000); chk("R9", rd_data, 16'h01E1);
      set_tgt(PHY, 8'd2); wr(16'hFFFF); chk("R9", rd_data, IDH);
      set_tgt(PHY, 8'd9); wr(16'h1234);
      rd("R9", PHY, 8'd0, 16'h1200);
      rd("R9", PHY, 8'd4, 16'h0061);
      // R4 write through mismatched address is dropped
      set_tgt(8'h05, 8'd0); wr(16'h0AAA);
      rd("R4", PHY, 8'd0, 16'h1200);
      // R8 soft reset, value not stored
      set_tgt(PHY, 8'd0); wr(16'h8100); chk("R8", rd_data, 16'h3100);
      rd("R8", PHY, 8'd4, 16'h01E1);
      rd("R8", PHY, 8'd1, 16'h786D);
      // R3 link down
      link(1'b0);
      rd("R3", PHY, 8'd1, 16'h7849);
      rd("R3", PHY, 8'd5, 16'h0080);
      // R10 data write and target load in the same cycle
      set_tgt(PHY, 8'd0);
      @(negedge clk); wr_en = 1'b1; wr_data = 16'h0041; tgt_wr = 1'b1; tgt_wdata = {PHY, 8'd4};
      @(negedge clk); wr_en = 1'b0; tgt_wr = 1'b0;
      chk("R10", rd_data, 16'h01E1);
      rd("R10", PHY, 8'd0, 16'h0041);
      // R8 with R2: soft reset and link rise in the same cycle
      set_tgt(PHY, 8'd4); wr(16'h0021);
      set_tgt(PHY, 8'd0);
      @(negedge clk); wr_en = 1'b1; wr_data = 16'h8000; link_up = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      chk("R8", rd_data, 16'h3100);
      rd("R8", PHY, 8'd4, 16'h01E1);
      rd("R2", PHY, 8'd1, 16'h786D);
      rd("R2", PHY, 8'd5, 16'h01E1);
      // R3 link falls during a control write
      set_tgt(PHY, 8'd0);
      @(negedge clk); wr_en = 1'b1; wr_data = 16'h0100; link_up = 1'b0;
      @(negedge clk); wr_en = 1'b0;
      chk("R7", rd_data, 16'h0100);
      rd("R3", PHY, 8'd1, 16'h7849);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule